// File: doc/BRIEF.md
# Up/Down Interval Timer with Reload, Compare and Capture

This block is a 16-bit timer/counter that moves one step on each cycle where the count-enable input is high. It counts either upward or downward. Compare register 0 serves two purposes. When counting up it sets the interval, because the counter returns to zero after matching it. When counting down it supplies the value loaded into the counter after an underflow, provided reload is enabled. Compare register 1 raises its own match pulse and does not affect the count.

Each of the two capture/compare channels has two modes. In compare mode it behaves like compare register 1. In capture mode it copies the current count into its register when its external trigger shows the chosen edge; the trigger first passes through a synchronizer. All registers are written through a simple write-enable/address/data port. They are read back through a combinational read port, and the count is also driven on its own output.

The counting direction is held in a two-state machine, `DIR_UP` and `DIR_DOWN`. There are only two transitions. A control write with bit 7 set moves the machine to `DIR_DOWN`, and a control write with bit 7 clear moves it to `DIR_UP`. Any other cycle keeps the current state.

Top module: `updn_timer`

## Requirements
- R1: After reset the count is 0x0000, every interrupt output is low, and every register reads 0. This means the direction is up, reload is off, and both capture/compare channels are in compare mode with rising-edge selection.
- R2: The count changes only on a cycle with `cnt_en` high or on a write to the count register. When counting up and nothing matches, the count goes up by one.
- R3: When counting up, an enabled cycle whose count equals compare register 0 loads 0x0000 into the counter. On the cycle after that edge, `irq_cmp[0]` is high for exactly one cycle.
- R4: When counting down, an enabled cycle whose count equals compare register 0 still decrements the counter by one and pulses `irq_cmp[0]`.
- R5: When counting down with reload on (control bit 0), an enabled cycle at count 0x0000 loads the value of compare register 0 instead of decrementing.
- R6: When counting down with reload off, an enabled cycle at 0x0000 wraps the count to 0xFFFF.
- R7: An enabled cycle whose count equals compare register 1 pulses `irq_cmp[1]` and leaves the counting unchanged.
- R8: A capture/compare channel in compare mode pulses `irq_cc[i]` on an enabled cycle whose count equals its register. In capture mode (control bit 1 for channel 0, bit 2 for channel 1), a count match gives no pulse.
- R9: In capture mode, a qualifying edge on `cap_in[i]` stores the count into that channel's register and pulses `irq_cc[i]`. The pulse appears on the third rising clock edge after the input changes. The edge select is in control bits 4:3 for channel 0 and bits 6:5 for channel 1: 00 means rising, 01 means falling, and 1x means both.
- R10: The register addresses are: 0 for compare 0, 1 for compare 1, 2 for capture/compare 0, 3 for capture/compare 1, 4 for control and 5 for the count. A write to address 5 loads the count. On that cycle it takes priority over counting, so the count neither advances nor raises a count-match pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count-clock enable, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| cap_in | input | 2 | Asynchronous capture triggers, one per capture/compare channel |
| count_q | output | 16 | Current count |
| irq_cmp | output | 2 | Match pulses for compare registers 0 and 1 |
| irq_cc | output | 2 | Match or capture pulses for the capture/compare channels |

## Verification
The hardest state to reach is a down-count that arrives at 0x0000 with reload on while other registers hold values that could also match. Every compare register resets to zero, so the bench first moves all of them away from zero. It then climbs to an up-count interval match, switches direction and walks down through each compare value in turn. This separates reload, the down-count match and the wrap with reload off, each on its own cycle.

The capture path is tested with the count frozen. This lets the stored value and the three-edge latency be predicted exactly for each edge-select setting.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_e;

    typedef struct packed {
        logic [1:0] edge1;
        logic [1:0] edge0;
        logic       cap1;
        logic       cap0;
        logic       reload;
    } ctrl_t;

    localparam int ADDR_W   = 3;
    localparam int CTRL_W   = 7;
    localparam int DIR_BIT  = 7;
    localparam logic [ADDR_W-1:0] A_CMP0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_CC0  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CC1  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;
endpackage

// File: rtl/updn_timer_capsync.sv
module updn_timer_capsync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_in,
    input  logic [1:0] edge_sel,
    output logic       edge_hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic                   fall;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b0;
                end else begin
                    sync_q[g] <= (g == 0) ? sig_in : sync_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    always_comb begin
        rise = sync_q[SYNC_STAGES-1] & ~prev_q;
        fall = ~sync_q[SYNC_STAGES-1] & prev_q;
        if (edge_sel[1]) begin
            edge_hit = rise | fall;
        end else if (edge_sel[0]) begin
            edge_hit = fall;
        end else begin
            edge_hit = rise;
        end
    end
endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             dir_wr,
    input  logic             dir_val,
    input  logic             reload,
    input  logic [CNT_W-1:0] cmp0,
    output logic [CNT_W-1:0] count_q,
    output logic             dir_down
);
    dir_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_d;
    logic             at_zero;
    logic             hit0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= DIR_UP;
            count_q <= '0;
        end else begin
            st_q    <= st_d;
            count_q <= cnt_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (dir_wr) begin
            st_d = dir_val ? DIR_DOWN : DIR_UP;
        end
    end

    // outputs and count update
    always_comb begin
        at_zero  = (count_q == '0);
        hit0     = (count_q == cmp0);
        dir_down = (st_q == DIR_DOWN);
        cnt_d    = count_q;
        if (wr_cnt) begin
            cnt_d = wr_val;
        end else if (cnt_en) begin
            unique case (st_q)
                DIR_UP:   cnt_d = hit0 ? '0 : count_q + 1'b1;
                DIR_DOWN: cnt_d = (reload && at_zero) ? cmp0 : count_q - 1'b1;
                default:  cnt_d = count_q;
            endcase
        end
    end
endmodule

// File: rtl/updn_timer.sv
module updn_timer
    import updn_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int N_CC    = 2,
    parameter int N_SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic [N_CC-1:0]  cap_in,
    output logic [CNT_W-1:0] count_q,
    output logic [1:0]       irq_cmp,
    output logic [N_CC-1:0]  irq_cc
);
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  cmp0_q, cmp1_q;
    logic [CNT_W-1:0]  ccv_q [N_CC];
    logic [N_CC-1:0]   cap_mode;
    logic [N_CC-1:0]   cap_hit;
    logic [1:0]        esel [N_CC];
    logic              wr_cnt, wr_ctrl, advance, dir_down;

    assign wr_cnt   = wr_en && (wr_addr == A_CNT);
    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign advance  = cnt_en && !wr_cnt;
    assign cap_mode = {ctrl_q.cap1, ctrl_q.cap0};
    assign esel[0]  = ctrl_q.edge0;
    assign esel[1]  = ctrl_q.edge1;

    updn_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .wr_cnt   (wr_cnt),
        .wr_val   (wr_data),
        .dir_wr   (wr_ctrl),
        .dir_val  (wr_data[DIR_BIT]),
        .reload   (ctrl_q.reload),
        .cmp0     (cmp0_q),
        .count_q  (count_q),
        .dir_down (dir_down)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cmp0_q  <= '0;
            cmp1_q  <= '0;
            irq_cmp <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_en && wr_addr == A_CMP0) cmp0_q <= wr_data;
            if (wr_en && wr_addr == A_CMP1) cmp1_q <= wr_data;
            irq_cmp[0] <= advance && (count_q == cmp0_q);
            irq_cmp[1] <= advance && (count_q == cmp1_q);
        end
    end

    genvar c;
    generate
        for (c = 0; c < N_CC; c++) begin : g_cc
            updn_timer_capsync #(.SYNC_STAGES(N_SYNC)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .sig_in   (cap_in[c]),
                .edge_sel (esel[c]),
                .edge_hit (cap_hit[c])
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ccv_q[c]  <= '0;
                    irq_cc[c] <= 1'b0;
                end else begin
                    if (wr_en && wr_addr == A_CC0 + 3'(c)) begin
                        ccv_q[c] <= wr_data;
                    end else if (cap_mode[c] && cap_hit[c]) begin
                        ccv_q[c] <= count_q;
                    end
                    irq_cc[c] <= cap_mode[c] ? cap_hit[c]
                                             : (advance && (count_q == ccv_q[c]));
                end
            end
        end
    endgenerate

    always_comb begin
        unique case (rd_addr)
            A_CMP0:  rd_data = cmp0_q;
            A_CMP1:  rd_data = cmp1_q;
            A_CC0:   rd_data = ccv_q[0];
            A_CC1:   rd_data = ccv_q[1];
            A_CTRL:  rd_data = CNT_W'({dir_down, ctrl_q});
            A_CNT:   rd_data = count_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [CNT_W-1:0] count_q,
    input logic [1:0]       irq_cmp,
    input logic             dir_down,
    input logic             reload,
    input logic [CNT_W-1:0] cmp0
);
    logic adv;
    assign adv = cnt_en && !(wr_en && wr_addr == 3'd5);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_en) && !$past(wr_en)) |-> $stable(count_q));

    p_irq0_on_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmp[0] |-> $past(cnt_en));

    p_up_match_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv && !dir_down && count_q == cmp0) |-> count_q == '0);

    p_down_match_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv && dir_down && count_q == cmp0 && count_q != '0)
        |-> count_q == $past(count_q) - 1'b1);

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv && dir_down && reload && count_q == '0) |-> count_q == $past(cmp0));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv && dir_down && !reload && count_q == '0) |-> count_q == '1);
endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .count_q  (count_q),
    .irq_cmp  (irq_cmp),
    .dir_down (dir_down),
    .reload   (ctrl_q.reload),
    .cmp0     (cmp0_q)
);

// File: tb/updn_timer_tb.sv
module updn_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnt_en, wr_en;
    logic [2:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data, count_q;
    logic [1:0]  cap_in, irq_cmp, irq_cc;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    updn_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cap_in(cap_in), .count_q(count_q),
        .irq_cmp(irq_cmp), .irq_cc(irq_cc)
    );

    // {we, addr, data, en, expected count, expected irq {cc1,cc0,cmp1,cmp0}}
    localparam logic [40:0] VECS [0:28] = '{
        {1'b1, 3'd2, 16'h0E00, 1'b0, 16'h0000, 4'h0},
        {1'b1, 3'd3, 16'h00F0, 1'b0, 16'h0000, 4'h0},
        {1'b1, 3'd1, 16'h0F00, 1'b0, 16'h0000, 4'h0},
        {1'b1, 3'd0, 16'h0003, 1'b0, 16'h0000, 4'h0},
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0001, 4'h0}, // R2
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0002, 4'h0},
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0003, 4'h0},
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0000, 4'h1}, // R3 clear
        {1'b0, 3'd0, 16'h0000, 1'b0, 16'h0000, 4'h0}, // R2 hold, R3 single pulse
        {1'b1, 3'd1, 16'h0001, 1'b0, 16'h0000, 4'h0},
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0001, 4'h0},
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0002, 4'h2}, // R7
        {1'b1, 3'd2, 16'h0002, 1'b0, 16'h0002, 4'h0},
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0003, 4'h4}, // R8 compare
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0000, 4'h1},
        {1'b1, 3'd4, 16'h0081, 1'b0, 16'h0000, 4'h0},
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0003, 4'h0}, // R5 reload
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0002, 4'h1}, // R4
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0001, 4'h4},
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h0000, 4'h2},
        {1'b1, 3'd4, 16'h0080, 1'b0, 16'h0000, 4'h0},
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'hFFFF, 4'h0}, // R6 wrap
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'hFFFE, 4'h0},
        {1'b1, 3'd5, 16'h00F1, 1'b0, 16'h00F1, 4'h0}, // R10 load
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h00F0, 4'h0},
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h00EF, 4'h8},
        {1'b1, 3'd4, 16'h0084, 1'b0, 16'h00EF, 4'h0},
        {1'b1, 3'd5, 16'h00F0, 1'b1, 16'h00F0, 4'h0}, // R10 write wins
        {1'b0, 3'd0, 16'h0000, 1'b1, 16'h00EF, 4'h0}  // R8 capture mode, no match pulse
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        rd_addr = a;
        #0.5;
        chk(req, rd_data, exp);
    endtask

    task automatic wait_irq(input string req, input int ch, input int edge_no);
        for (int k = 1; k <= 4; k++) begin
            step();
            chk(req, irq_cc[ch], (k == edge_no));
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0; wr_addr = '0;
        wr_data = '0; rd_addr = '0; cap_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 count", count_q, 16'h0);
        chk("R1 irq", {irq_cc, irq_cmp}, 4'h0);
        rd_chk("R1 ctrl", 3'd4, 16'h0);
        rd_chk("R1 cc1", 3'd3, 16'h0);

        for (int i = 0; i < 29; i++) begin
            wr_en   = VECS[i][40];
            wr_addr = VECS[i][39:37];
            wr_data = VECS[i][36:21];
            cnt_en  = VECS[i][20];
            step();
            if (count_q !== VECS[i][19:4] || {irq_cc, irq_cmp} !== VECS[i][3:0]) begin
                n_fail++;
                $display("FAIL table step %0d (R2 R3 R4 R5 R6 R7 R8 R10): actual %h/%h expected %h/%h",
                         i, count_q, {irq_cc, irq_cmp}, VECS[i][19:4], VECS[i][3:0]);
            end
            n_chk++;
        end
        wr_en = 1'b0; cnt_en = 1'b0;

        // R9 rising edge capture on channel 0, count frozen at 0x00EF
        wr(3'd4, 16'h0002);
        cap_in[0] = 1'b1;
        wait_irq("R9 rise latency", 0, 3);
        rd_chk("R9 rise value", 3'd2, 16'h00EF);
        cap_in[0] = 1'b0;
        wait_irq("R9 rise ignores fall", 0, 0);

        // R9 falling edge select
        wr(3'd4, 16'h000A);
        wr(3'd5, 16'h1234);
        cap_in[0] = 1'b1;
        wait_irq("R9 fall ignores rise", 0, 0);
        cap_in[0] = 1'b0;
        wait_irq("R9 fall edge", 0, 3);
        rd_chk("R9 fall value", 3'd2, 16'h1234);

        // R9 both edges on channel 1
        wr(3'd4, 16'h0044);
        wr(3'd5, 16'h0055);
        cap_in[1] = 1'b1;
        wait_irq("R9 both rise", 1, 3);
        rd_chk("R9 both rise value", 3'd3, 16'h0055);
        wr(3'd5, 16'h0066);
        cap_in[1] = 1'b0;
        wait_irq("R9 both fall", 1, 3);
        rd_chk("R9 both fall value", 3'd3, 16'h0066);

        // R1 reset mid-run
        rst_n = 1'b0;
        step();
        chk("R1 count after reset", count_q, 16'h0);
        rd_chk("R1 ctrl after reset", 3'd4, 16'h0);
        rd_chk("R1 cmp0 after reset", 3'd0, 16'h0);
        rd_chk("R1 cc0 after reset", 3'd2, 16'h0);
        rst_n = 1'b1;
        step();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule